// File: doc/BRIEF.md
# Activity-Driven Grouped Clock Gater

This block holds a bank of flip-flops split into equal groups and feeds each group a clock that pulses only when that group has something to store. Before every rising edge each flip-flop's incoming value is compared with the value it already holds. The per-bit differences of a group are reduced by an OR tree into one enable. A latch that is transparent while the clock is low captures the enable, and the latch output is ANDed with the clock. A group whose inputs all equal its outputs therefore sees no edge at all.

A group with at least one changing bit receives a full pulse, and its unchanged members are clocked as well. That extra clocking is the price of sharing one latch and one AND gate across the group. The group size is a parameter and sets the balance between the cost of the gaters and the pulses that reach unchanged bits. From the outside the bank behaves exactly like a plain register clocked on every edge. A free-running cycle counter and one enabled-edge counter per group show how often each gated clock actually fired.

Top module: `dgate_reg_group`

## Requirements
- R1: While `rst_n` is low, `q`, `cyc_count` and every field of `en_count` are zero. Reset acts asynchronously, so it takes effect without a clock edge, and it also clears groups whose clock is suppressed.
- R2: After reset, `q` after every rising edge of `clk` equals the `d` that was present just before that edge, for any input sequence. This is the same result an ungated register would give.
- R3: Group g covers `d`/`q` bits [g*GROUP_K +: GROUP_K]. When any bit of group g differs between `d` and `q` before a rising edge, `grp_gclk[g]` is high for the high phase that follows. All bits of the group are loaded on that pulse.
- R4: When every bit of group g has `d` equal to `q` before a rising edge, `grp_gclk[g]` stays low for the whole following cycle.
- R5: `grp_gclk` is low throughout every low phase of `clk`. The enable is allowed to change only while `clk` is low, so the gated clock cannot glitch.
- R6: `cyc_count` increments by one on every rising edge of `clk` outside reset and wraps modulo 2^CNT_W.
- R7: `en_count[g*CNT_W +: CNT_W]` increments by one on exactly those rising edges where group g is enabled. It wraps modulo 2^CNT_W.
- R8: GROUP_K must be 2, 4, 8 or 16, and WIDTH must be a multiple of GROUP_K. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d | input | WIDTH | Next-state values of the bank |
| q | output | WIDTH | Stored values of the bank |
| grp_gclk | output | WIDTH/GROUP_K | Gated clock of each group |
| cyc_count | output | CNT_W | Count of clock edges since reset |
| en_count | output | (WIDTH/GROUP_K)*CNT_W | Per-group count of edges that fired |

## Verification
A value placed on `d` during a low phase shows up on `q` and in the counters after the next rising edge. Its gated-clock pulse appears during the high phase that begins at that same edge. The bench drives `d` shortly after each falling edge. It checks `grp_gclk` a quarter period after the rising edge, and it checks `q`, the counters and the low gated clock one time unit after the following falling edge. Expected values come from an ungated reference copy of the bank, a per-group comparison of old and new values, and modulo-256 arithmetic, so each result is sampled in the cycle where it is due. The input sweeps include every 8-bit value in order, held pairs, changes confined to one group, single-bit flips, and an asynchronous reset taken mid-run during a high phase.

// File: rtl/dgate_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the grouped clock gater.
// Assumes: group sizes are small powers of two.
package dgate_pkg;

    // Legal group sizes for one shared gater
    function automatic bit group_size_ok(input int k);
        return (k == 2) || (k == 4) || (k == 8) || (k == 16);
    endfunction

endpackage

// File: rtl/dgate_change_detect.sv
`timescale 1ns/1ps
// Module: dgate_change_detect
// Compares each bit's next value with its stored value and reduces the
// differences through a balanced OR tree into one group enable.
// Assumes: K is a power of two (checked at the top).
module dgate_change_detect #(
    parameter int K = 4
) (
    input  logic [K-1:0] d_grp,
    input  logic [K-1:0] q_grp,
    output logic         any_change
);
    localparam int LEVELS = $clog2(K);

    genvar lvl, i;
    generate
        for (lvl = 0; lvl <= LEVELS; lvl++) begin : g_lvl
            logic [(K >> lvl)-1:0] v;
            if (lvl == 0) begin : g_leaf
                // Per-bit difference between next and stored value
                assign v = d_grp ^ q_grp;
            end else begin : g_node
                for (i = 0; i < (K >> lvl); i++) begin : g_or
                    // Pairwise OR of the level below
                    assign v[i] = g_lvl[lvl-1].v[2*i] | g_lvl[lvl-1].v[2*i+1];
                end
            end
        end
    endgenerate

    assign any_change = g_lvl[LEVELS].v[0];

endmodule

// File: rtl/dgate_clock_gate.sv
`timescale 1ns/1ps
// Module: dgate_clock_gate
// Glitch-free gater: the enable is held by a latch that is open only
// while clk is low, and the latch output is ANDed with clk.
// Assumes: en settles during the low phase of clk.
module dgate_clock_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_hold;

    // Latch the enable while the clock is low
    always_latch begin
        if (!clk) en_hold = en;
    end

    // Pass the clock only when the held enable is set
    assign gclk = clk & en_hold;

endmodule

// File: rtl/dgate_reg_bank.sv
`timescale 1ns/1ps
// Module: dgate_reg_bank
// One group's flip-flops, clocked by that group's gated clock.
// Assumes: rst_n is asynchronous, so the bank clears without a gated edge.
module dgate_reg_bank #(
    parameter int K = 4
) (
    input  logic         gclk,
    input  logic         rst_n,
    input  logic [K-1:0] d_grp,
    output logic [K-1:0] q_grp
);
    // Load the group on its gated edge, clear on reset
    always_ff @(posedge gclk or negedge rst_n) begin
        if (!rst_n) q_grp <= '0;
        else        q_grp <= d_grp;
    end

endmodule

// File: rtl/dgate_stats.sv
`timescale 1ns/1ps
// Module: dgate_stats
// Counts every clock edge and, for each group, the edges where it fired.
// Assumes: grp_en is stable before each rising edge of clk.
module dgate_stats #(
    parameter int NG    = 2,
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NG-1:0]       grp_en,
    output logic [CNT_W-1:0]    cyc_count,
    output logic [NG*CNT_W-1:0] en_count
);
    // Free-running cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_count <= '0;
        else        cyc_count <= cyc_count + 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < NG; g++) begin : g_cnt
            logic [CNT_W-1:0] cnt;
            // Count edges on which group g was enabled
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        cnt <= '0;
                else if (grp_en[g]) cnt <= cnt + 1'b1;
            end
            assign en_count[g*CNT_W +: CNT_W] = cnt;
        end
    endgenerate

endmodule

// File: rtl/dgate_reg_group.sv
`timescale 1ns/1ps
// Module: dgate_reg_group (top)
// Register bank split into groups of GROUP_K bits. Each group is clocked
// only when one of its bits would change; edge statistics are counted.
// Assumes: GROUP_K in {2,4,8,16} and WIDTH a multiple of GROUP_K.
module dgate_reg_group #(
    parameter int WIDTH   = 32,
    parameter int GROUP_K = 4,
    parameter int CNT_W   = 16,
    localparam int NUM_GROUPS = WIDTH / GROUP_K
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WIDTH-1:0]            d,
    output logic [WIDTH-1:0]            q,
    output logic [NUM_GROUPS-1:0]       grp_gclk,
    output logic [CNT_W-1:0]            cyc_count,
    output logic [NUM_GROUPS*CNT_W-1:0] en_count
);
    import dgate_pkg::*;

    // R8: refuse illegal configurations at elaboration
    generate
        if (!group_size_ok(GROUP_K) || (WIDTH % GROUP_K) != 0) begin : g_bad_cfg
            $error("dgate_reg_group: GROUP_K must be 2/4/8/16 and divide WIDTH");
        end
    endgenerate

    logic [NUM_GROUPS-1:0] grp_en;

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            dgate_change_detect #(.K(GROUP_K)) u_det (
                .d_grp      (d[g*GROUP_K +: GROUP_K]),
                .q_grp      (q[g*GROUP_K +: GROUP_K]),
                .any_change (grp_en[g])
            );

            dgate_clock_gate u_cg (
                .clk  (clk),
                .en   (grp_en[g]),
                .gclk (grp_gclk[g])
            );

            dgate_reg_bank #(.K(GROUP_K)) u_bank (
                .gclk  (grp_gclk[g]),
                .rst_n (rst_n),
                .d_grp (d[g*GROUP_K +: GROUP_K]),
                .q_grp (q[g*GROUP_K +: GROUP_K])
            );
        end
    endgenerate

    dgate_stats #(.NG(NUM_GROUPS), .CNT_W(CNT_W)) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_en    (grp_en),
        .cyc_count (cyc_count),
        .en_count  (en_count)
    );

endmodule

// File: rtl/dgate_reg_group_chk.sv
`timescale 1ns/1ps
// Module: dgate_reg_group_chk
// Checker bound to dgate_reg_group; relates its ports over time.
// Assumes: same parameters as the bound instance.
module dgate_reg_group_chk #(
    parameter int WIDTH   = 32,
    parameter int GROUP_K = 4,
    parameter int CNT_W   = 16,
    localparam int NUM_GROUPS = WIDTH / GROUP_K
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [WIDTH-1:0]            d,
    input logic [WIDTH-1:0]            q,
    input logic [NUM_GROUPS-1:0]       grp_gclk,
    input logic [CNT_W-1:0]            cyc_count,
    input logic [NUM_GROUPS*CNT_W-1:0] en_count
);
    // Reset holds everything at zero
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (q == '0 && cyc_count == '0 && en_count == '0)
                else $error("R1: state not cleared during reset");
        end
    end

    // Stored value follows the previous input like an ungated register
    assert_q_follows_d_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q == $past(d)));

    // Gated clocks are low at the end of every low phase
    assert_gclk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grp_gclk == '0);

    // Cycle counter steps by one per edge
    assert_cyc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cyc_count == $past(cyc_count) + 1'b1));

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_chk
            // Group counter steps exactly when the group had a change
            assert_en_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |->
                (en_count[g*CNT_W +: CNT_W] ==
                 $past(en_count[g*CNT_W +: CNT_W]) +
                 CNT_W'($past(|(d[g*GROUP_K +: GROUP_K] ^ q[g*GROUP_K +: GROUP_K])))));

            // Unchanged group keeps its stored bits
            assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (d[g*GROUP_K +: GROUP_K] == q[g*GROUP_K +: GROUP_K])
                |=> $stable(q[g*GROUP_K +: GROUP_K]));
        end
    endgenerate

endmodule

bind dgate_reg_group dgate_reg_group_chk #(
    .WIDTH   (WIDTH),
    .GROUP_K (GROUP_K),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .d         (d),
    .q         (q),
    .grp_gclk  (grp_gclk),
    .cyc_count (cyc_count),
    .en_count  (en_count)
);

// File: tb/test_dgate_reg_group.sv
`timescale 1ns/1ps
// Bench: 8-bit bank in two groups of four, 8-bit counters.
module test_dgate_reg_group;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int K  = 4;
    localparam int CW = 8;
    localparam int NG = W / K;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [W-1:0]      d;
    logic [W-1:0]      q;
    logic [NG-1:0]     grp_gclk;
    logic [CW-1:0]     cyc_count;
    logic [NG*CW-1:0]  en_count;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0]  ref_q;
    logic [CW-1:0] exp_cyc;
    logic [CW-1:0] exp_en [NG];
    logic [NG-1:0] exp_fire;

    dgate_reg_group #(.WIDTH(W), .GROUP_K(K), .CNT_W(CW)) i_dgate_reg_group (
        .clk       (clk),
        .rst_n     (rst_n),
        .d         (d),
        .q         (q),
        .grp_gclk  (grp_gclk),
        .cyc_count (cyc_count),
        .en_count  (en_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state();
        check(q == ref_q, "R2 q", int'(q), int'(ref_q));
        check(grp_gclk == '0, "R5 gclk low phase", int'(grp_gclk), 0);
        check(cyc_count == exp_cyc, "R6 cyc_count", int'(cyc_count), int'(exp_cyc));
        for (int g = 0; g < NG; g++)
            check(en_count[g*CW +: CW] == exp_en[g], "R7 en_count",
                  int'(en_count[g*CW +: CW]), int'(exp_en[g]));
    endtask

    // Called shortly after a falling edge: apply value, follow one full cycle
    task automatic step(input logic [W-1:0] nd);
        d = nd;
        for (int g = 0; g < NG; g++)
            exp_fire[g] = (nd[g*K +: K] != ref_q[g*K +: K]);
        @(posedge clk);
        #(CLK_PERIOD/4);
        for (int g = 0; g < NG; g++) begin
            if (exp_fire[g])
                check(grp_gclk[g] == 1'b1, "R3 pulse on change", int'(grp_gclk[g]), 1);
            else
                check(grp_gclk[g] == 1'b0, "R4 no pulse when idle", int'(grp_gclk[g]), 0);
        end
        ref_q   = nd;
        exp_cyc = exp_cyc + 1'b1;
        for (int g = 0; g < NG; g++)
            exp_en[g] = exp_en[g] + CW'(exp_fire[g]);
        @(negedge clk);
        #1;
        check_state();
    endtask

    task automatic clear_model();
        ref_q   = '0;
        exp_cyc = '0;
        for (int g = 0; g < NG; g++) exp_en[g] = '0;
    endtask

    initial begin
        rst_n = 1'b0;
        d     = 8'hA5;
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        check(q == '0, "R1 q in reset", int'(q), 0);
        check(cyc_count == '0 && en_count == '0, "R1 counters in reset",
              int'(cyc_count), 0);
        rst_n = 1'b1;
        d     = '0;

        // Exhaustive ascending sweep
        for (int i = 0; i < 256; i++) step(W'(i));
        // Held pairs: every second cycle changes nothing
        for (int i = 0; i < 256; i++) step({W'(i)} & 8'hFE);
        // Only the upper group moves, lower group pinned
        for (int i = 0; i < 32; i++) step({4'(i), 4'h5});
        // Single-bit flips: one bit changes, whole group loads
        for (int r = 0; r < 2; r++)
            for (int b = 0; b < W; b++) step(ref_q ^ (W'(1) << b));
        // Same value repeated: no group fires
        for (int i = 0; i < 4; i++) step(ref_q);

        // R1: asynchronous reset in the middle of a high phase
        d = 8'h3C;
        @(posedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        check(q == '0, "R1 async clear q", int'(q), 0);
        check(cyc_count == '0 && en_count == '0, "R1 async clear counters",
              int'(en_count), 0);
        clear_model();
        @(negedge clk);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        d     = '0;
        step(8'h00);
        step(8'hF0);
        step(8'hF0);
        step(8'h0F);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule